// File: doc/BRIEF.md
# BCD Time-of-Day Calendar with Alarm

This block keeps wall-clock time for a chip from a one-pulse-per-second tick. Hours, minutes and seconds are held in packed BCD. The date is a free-running 15-bit binary day number. Software maps day numbers to calendar dates. Every value is reached through 8-bit registers on a simple address/data port. Writes are synchronous. Reads are combinational from the address.

An alarm comparator checks the minute, hour and day once per minute, at the moment the seconds roll over to 00. Each of the three fields has its own enable, and a field that is not enabled always counts as a match. A match sets a sticky flag whether or not interrupts are enabled. The interrupt output is the flag gated by the interrupt enable, and software clears the flag by writing a one to it.

While the counters are advancing, the busy bit in the control register reads as one. A register write that lands in that cycle is held in a one-entry holding register and takes effect one cycle later, so it never races the count.

Top module: `bcd_calendar_alarm`

## Requirements
- R1: When control bit 0 (count enable) is set, each clock with `tick` high advances the seconds register (address 0x15) by one in BCD, and 0x59 is followed by 0x00. When the enable is clear, a tick changes no time register.
- R2: A seconds wrap carries into the minutes register (0x16, BCD, 0x59 wraps to 0x00). A minutes wrap carries into the hours register (0x17, BCD, 0x23 wraps to 0x00). BCD digit carries hold, for example hour 0x09 becomes 0x10.
- R3: An hours wrap increments the 15-bit binary day count. Its low byte is at 0x18 and its upper 7 bits are at 0x19, whose bit 7 always reads 0. The count wraps from 0x7FFF to 0.
- R4: A write to any time or alarm register (minute 0x1A, hour 0x1B, day low 0x1C, day high 0x1D) takes effect at the next clock edge and reads back through the same address.
- R5: The control register is at 0x14. Bit 7 reads 1 exactly in a cycle where `tick` is high with counting enabled, and reads 0 otherwise. Writes to bit 7 have no effect, and bit 6 reads 0.
- R6: A write issued while busy is held and applied one cycle after the counters advance, so the written value replaces the advanced one.
- R7: The alarm is evaluated only on an advance that brings seconds to 00. It matches when each field is either disabled or equal to its alarm register. The enables are control bit 3 (minute), bit 4 (hour) and bit 5 (day).
- R8: Control bit 2 is the alarm flag. A match sets it whether or not the interrupt is enabled. Writing 1 to bit 2 clears it, and writing 0 to bit 2 leaves it unchanged.
- R9: `irq` is high exactly when the alarm flag and control bit 1 (interrupt enable) are both set.
- R10: After reset every register reads 0x00 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that `tick` is never high in two consecutive clocks. They also assume that at most one write arrives while a held write is still waiting, so the single holding slot never has to take a second value. The stimulus drives each tick as a one-cycle pulse separated by idle cycles, and issues at most one write per busy cycle. All other writes are placed with `tick` low. Time values are always loaded as legal BCD, so rollover behaviour is only judged on values the counters can reach.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_CTL     = 8'h14;
  localparam logic [ADDR_W-1:0] ADR_SEC     = 8'h15;
  localparam logic [ADDR_W-1:0] ADR_MIN     = 8'h16;
  localparam logic [ADDR_W-1:0] ADR_HOUR    = 8'h17;
  localparam logic [ADDR_W-1:0] ADR_DAY_LO  = 8'h18;
  localparam logic [ADDR_W-1:0] ADR_DAY_HI  = 8'h19;
  localparam logic [ADDR_W-1:0] ADR_AMIN    = 8'h1A;
  localparam logic [ADDR_W-1:0] ADR_AHOUR   = 8'h1B;
  localparam logic [ADDR_W-1:0] ADR_ADAY_LO = 8'h1C;
  localparam logic [ADDR_W-1:0] ADR_ADAY_HI = 8'h1D;

  typedef struct packed {
    logic              advance;
    logic              apply;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } calStrb_t;

  // returns {carry, next value} of a two-digit BCD counter
  function automatic logic [DATA_W:0] bcdInc(input logic [DATA_W-1:0] v,
                                             input logic [DATA_W-1:0] lastVal);
    logic [DATA_W:0] r;
    if (v == lastVal)          r = {1'b1, 8'h00};
    else if (v[3:0] == 4'h9)   r = {1'b0, v[7:4] + 4'h1, 4'h0};
    else                       r = {1'b0, v[7:4], v[3:0] + 4'h1};
    return r;
  endfunction
endpackage

// File: rtl/bcd_cal_ctrl.sv
module bcd_cal_ctrl
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              almHit,
  output calStrb_t          strb,
  output logic [2:0]        fieldEn,
  output logic [DATA_W-1:0] ctlRd,
  output logic              irq
);
  logic calEnQ, intEnQ, flagQ;
  logic [2:0] fieldEnQ;
  logic pendV;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;
  logic busy, apply, ctlWr, flagClr;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] effData;

  assign busy    = tick && calEnQ;
  assign apply   = !busy && (pendV || wrEn);
  assign effAddr = pendV ? pendAddr : addr;
  assign effData = pendV ? pendData : wrData;
  assign ctlWr   = apply && (effAddr == ADR_CTL);
  assign flagClr = ctlWr && effData[2];

  assign strb    = '{advance: busy, apply: apply, addr: effAddr, data: effData};
  assign fieldEn = fieldEnQ;
  assign irq     = flagQ && intEnQ;
  assign ctlRd   = {busy, 1'b0, fieldEnQ, flagQ, intEnQ, calEnQ};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendV    <= 1'b0;
      pendAddr <= '0;
      pendData <= '0;
    end else if (wrEn && (busy || pendV)) begin
      pendV    <= 1'b1;
      pendAddr <= addr;
      pendData <= wrData;
    end else if (apply) begin
      pendV    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calEnQ   <= 1'b0;
      intEnQ   <= 1'b0;
      fieldEnQ <= '0;
    end else if (ctlWr) begin
      calEnQ   <= effData[0];
      intEnQ   <= effData[1];
      fieldEnQ <= effData[5:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               flagQ <= 1'b0;
    else if (busy && almHit)  flagQ <= 1'b1;
    else if (flagClr)         flagQ <= 1'b0;
  end

  AST_HELD_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && busy && !pendV) |=> (strb.apply && strb.addr == $past(addr))) // R6
    else $error("held write not applied");

  AST_FLAG_ONLY_ON_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagQ) |-> $past(busy)) // R8
    else $error("flag rose without advance");

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flagQ && !flagClr) |=> flagQ) // R8
    else $error("flag dropped without clear");

  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(calEnQ) && $stable(fieldEnQ)) // R6
    else $error("control changed by busy-cycle write");
endmodule

// File: rtl/bcd_cal_datapath.sv
module bcd_cal_datapath
  import bcd_cal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  calStrb_t          strb,
  input  logic [2:0]        fieldEn,
  output logic [DATA_W-1:0] secQ,
  output logic [DATA_W-1:0] minQ,
  output logic [DATA_W-1:0] hourQ,
  output logic [DAY_W-1:0]  dayQ,
  output logic [DATA_W-1:0] almMinQ,
  output logic [DATA_W-1:0] almHourQ,
  output logic [DAY_W-1:0]  almDayQ,
  output logic              almHit
);
  localparam int DAY_HI_W = DAY_W - DATA_W;

  logic [DATA_W:0] secInc, minInc, hourInc;
  logic [DATA_W-1:0] secNext, minNext, hourNext;
  logic [DAY_W-1:0] dayNext;
  logic minMatch, hourMatch, dayMatch;

  always_comb begin
    secInc   = bcdInc(secQ, 8'h59);
    minInc   = bcdInc(minQ, 8'h59);
    hourInc  = bcdInc(hourQ, 8'h23);
    secNext  = secInc[DATA_W-1:0];
    minNext  = secInc[DATA_W] ? minInc[DATA_W-1:0] : minQ;
    hourNext = (secInc[DATA_W] && minInc[DATA_W]) ? hourInc[DATA_W-1:0] : hourQ;
    dayNext  = (secInc[DATA_W] && minInc[DATA_W] && hourInc[DATA_W])
               ? DAY_W'(dayQ + 1'b1) : dayQ;
  end

  assign minMatch  = !fieldEn[0] || (minNext == almMinQ);
  assign hourMatch = !fieldEn[1] || (hourNext == almHourQ);
  assign dayMatch  = !fieldEn[2] || (dayNext == almDayQ);
  assign almHit    = (secNext == 8'h00) && minMatch && hourMatch && dayMatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secQ  <= '0;
      minQ  <= '0;
      hourQ <= '0;
      dayQ  <= '0;
    end else if (strb.advance) begin
      secQ  <= secNext;
      minQ  <= minNext;
      hourQ <= hourNext;
      dayQ  <= dayNext;
    end else if (strb.apply) begin
      case (strb.addr)
        ADR_SEC:    secQ  <= strb.data;
        ADR_MIN:    minQ  <= strb.data;
        ADR_HOUR:   hourQ <= strb.data;
        ADR_DAY_LO: dayQ[DATA_W-1:0]     <= strb.data;
        ADR_DAY_HI: dayQ[DAY_W-1:DATA_W] <= strb.data[DAY_HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      almMinQ  <= '0;
      almHourQ <= '0;
      almDayQ  <= '0;
    end else if (strb.apply) begin
      case (strb.addr)
        ADR_AMIN:    almMinQ  <= strb.data;
        ADR_AHOUR:   almHourQ <= strb.data;
        ADR_ADAY_LO: almDayQ[DATA_W-1:0]     <= strb.data;
        ADR_ADAY_HI: almDayQ[DAY_W-1:DATA_W] <= strb.data[DAY_HI_W-1:0];
        default: ;
      endcase
    end
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.advance && secQ == 8'h59) |=> (secQ == 8'h00)) // R1
    else $error("seconds did not wrap");

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.advance && !strb.apply) |=> ($stable(secQ) && $stable(dayQ))) // R1
    else $error("time moved without tick or write");

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.advance && secQ == 8'h59 && minQ == 8'h59 && hourQ == 8'h23 && (&dayQ))
      |=> (dayQ == '0)) // R3
    else $error("day count did not wrap");

  AST_HIT_AT_ZERO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.advance && almHit) |=> (secQ == 8'h00)) // R7
    else $error("alarm hit off the minute");
endmodule

// File: rtl/bcd_calendar_alarm.sv
module bcd_calendar_alarm
  import bcd_cal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  calStrb_t strb;
  logic [2:0] fieldEn;
  logic almHit;
  logic [DATA_W-1:0] ctlRd, secQ, minQ, hourQ, almMinQ, almHourQ;
  logic [DAY_W-1:0] dayQ, almDayQ;

  bcd_cal_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .almHit(almHit), .strb(strb), .fieldEn(fieldEn),
    .ctlRd(ctlRd), .irq(irq)
  );

  bcd_cal_datapath #(.DAY_W(DAY_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .fieldEn(fieldEn),
    .secQ(secQ), .minQ(minQ), .hourQ(hourQ), .dayQ(dayQ),
    .almMinQ(almMinQ), .almHourQ(almHourQ), .almDayQ(almDayQ), .almHit(almHit)
  );

  always_comb begin
    case (addr)
      ADR_CTL:     rdData = ctlRd;
      ADR_SEC:     rdData = secQ;
      ADR_MIN:     rdData = minQ;
      ADR_HOUR:    rdData = hourQ;
      ADR_DAY_LO:  rdData = dayQ[DATA_W-1:0];
      ADR_DAY_HI:  rdData = DATA_W'(dayQ >> DATA_W);
      ADR_AMIN:    rdData = almMinQ;
      ADR_AHOUR:   rdData = almHourQ;
      ADR_ADAY_LO: rdData = almDayQ[DATA_W-1:0];
      ADR_ADAY_HI: rdData = DATA_W'(almDayQ >> DATA_W);
      default:     rdData = '0;
    endcase
  end
endmodule

// File: tb/bcd_calendar_alarm_tb.sv
module bcd_calendar_alarm_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // scoreboard queues: address (0x100 means irq pin), expected value, tag
  int    qAddr[$];
  int    qExp[$];
  string qTag[$];

  always #10 clk = ~clk;

  bcd_calendar_alarm dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic expectVal(input int a, input int e, input string tag);
    qAddr.push_back(a);
    qExp.push_back(e);
    qTag.push_back(tag);
    wait (qAddr.size() == 0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tickOnce();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic setTime(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(8'h17, h);
    wr(8'h16, m);
    wr(8'h15, s);
  endtask

  // monitor: pops expectations and compares against the design
  initial begin
    forever begin
      int got;
      wait (qAddr.size() != 0);
      if (qAddr[0] == 32'h100) begin
        #1 got = int'(irq);
      end else begin
        addr = qAddr[0][7:0];
        #1 got = int'(rdData);
      end
      checks++;
      if (got != qExp[0]) begin
        errors++;
        $display("FAIL %s addr=0x%0h actual=0x%0h expected=0x%0h",
                 qTag[0], qAddr[0], got, qExp[0]);
      end
      void'(qAddr.pop_front());
      void'(qExp.pop_front());
      void'(qTag.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    expectVal(8'h14, 8'h00, "R10");
    expectVal(8'h15, 8'h00, "R10");
    expectVal(8'h19, 8'h00, "R10");
    expectVal(32'h100, 0, "R10");

    // R1 counting
    wr(8'h14, 8'h01);
    wr(8'h15, 8'h08);
    expectVal(8'h15, 8'h08, "R4");
    tickOnce();
    expectVal(8'h15, 8'h09, "R1");
    tickOnce();
    expectVal(8'h15, 8'h10, "R1");
    wr(8'h14, 8'h00);
    tickOnce();
    expectVal(8'h15, 8'h10, "R1");

    // R5 busy indication, read-only bit 7
    wr(8'h14, 8'h81);
    expectVal(8'h14, 8'h01, "R5");
    @(negedge clk);
    tick = 1'b1;
    expectVal(8'h14, 8'h81, "R5");
    @(negedge clk);
    tick = 1'b0;
    expectVal(8'h15, 8'h11, "R1");

    // R2 / R3 rollovers (all alarm fields disabled, so any minute wrap matches)
    wr(8'h18, 8'hFF);
    wr(8'h19, 8'hFF);
    expectVal(8'h19, 8'h7F, "R3");
    setTime(8'h23, 8'h59, 8'h59);
    tickOnce();
    expectVal(8'h15, 8'h00, "R2");
    expectVal(8'h16, 8'h00, "R2");
    expectVal(8'h17, 8'h00, "R2");
    expectVal(8'h18, 8'h00, "R3");
    expectVal(8'h19, 8'h00, "R3");
    expectVal(8'h14, 8'h05, "R7");
    setTime(8'h09, 8'h59, 8'h59);
    tickOnce();
    expectVal(8'h17, 8'h10, "R2");
    expectVal(8'h18, 8'h00, "R3");

    // R6 write held across busy
    setTime(8'h05, 8'h10, 8'h59);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; addr = 8'h16; wrData = 8'h42;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    expectVal(8'h16, 8'h11, "R6");
    expectVal(8'h15, 8'h00, "R6");
    @(negedge clk);
    expectVal(8'h16, 8'h42, "R6");

    // R4 alarm registers
    wr(8'h1A, 8'h05);
    wr(8'h1B, 8'h02);
    wr(8'h1C, 8'h03);
    wr(8'h1D, 8'h80);
    expectVal(8'h1A, 8'h05, "R4");
    expectVal(8'h1C, 8'h03, "R4");
    expectVal(8'h1D, 8'h00, "R4");

    // R7 / R8 / R9 alarm match
    wr(8'h14, 8'h39);   // count, all three field enables, clears old flag? no: bit2 clear
    wr(8'h14, 8'h3D);   // write 1 to flag bit: clear
    expectVal(8'h14, 8'h39, "R8");
    wr(8'h18, 8'h03);
    wr(8'h19, 8'h00);
    setTime(8'h02, 8'h04, 8'h59);
    tickOnce();
    expectVal(8'h14, 8'h3D, "R7");
    expectVal(32'h100, 0, "R9");
    wr(8'h14, 8'h3B);
    expectVal(8'h14, 8'h3F, "R8");
    expectVal(32'h100, 1, "R9");
    wr(8'h14, 8'h3F);
    expectVal(8'h14, 8'h3B, "R8");
    expectVal(32'h100, 0, "R9");

    // R7 mismatch on hour
    setTime(8'h03, 8'h04, 8'h59);
    tickOnce();
    expectVal(8'h14, 8'h3B, "R7");
    // R7 disabled hour field counts as match
    wr(8'h14, 8'h2B);
    setTime(8'h03, 8'h04, 8'h59);
    tickOnce();
    expectVal(8'h14, 8'h2F, "R7");
    expectVal(32'h100, 1, "R9");
    // R7 no evaluation off the minute
    wr(8'h14, 8'h2F);
    expectVal(8'h14, 8'h2B, "R8");
    tickOnce();
    expectVal(8'h15, 8'h01, "R1");
    expectVal(8'h14, 8'h2B, "R7");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule